// File: doc/BRIEF.md
# E1 Frame Alignment Synchronizer

This block finds and follows the frame boundary in a received 2.048 Mb/s E1 stream. It takes one NRZ bit per receive clock cycle. A frame holds 32 eight-bit timeslots. Every second frame carries a seven-bit alignment word in bits 2 to 8 of timeslot 0. The frames in between carry a 1 in bit 2 of timeslot 0.

While searching, the block slides a seven-bit window along the stream. It takes any match of the alignment word as a candidate and reloads its timeslot and bit counters at once to that position. The candidate is accepted only if the next frame has bit 2 set and the frame after that carries the alignment word again. Once locked, the block checks every alignment word. Three errored words in a row restart the search. An optional criterion does the same on three errored bit-2 positions in a row. A hold input stops the automatic restart but still reports that the criterion was met. A rising edge on the manual request restarts the search at any time.

Top module: `e1_frame_sync`

## Requirements
- R1: While reset is asserted and right after it, `los` is 1, `ts_cnt` and `bit_cnt` are 0, `align_frame` is 0, and `fas_err` and `resync_met` are 0.
- R2: `bit_cnt` counts 0 to 7, where bit 1 of a timeslot is `bit_cnt` 0. `ts_cnt` advances when `bit_cnt` wraps and goes from 31 back to 0. `align_frame` inverts at each wrap from timeslot 31 to timeslot 0. `frame_sync` is 1 exactly when both counters are 0.
- R3: While searching, the block compares a window against the word 0011011. The window holds the current bit and the six bits before it, with the oldest bit first. On a match, the next cycle shows `ts_cnt`=1, `bit_cnt`=0 and `align_frame`=1.
- R4: After a candidate, the block checks bit 2 of timeslot 0 in the next frame, and the alignment word in the frame after that. Each check is made at bit 8 of timeslot 0. If both pass, `los` falls in the cycle after that bit 8, with `ts_cnt`=1, `bit_cnt`=0 and `align_frame`=1. If either check fails, the search resumes with the following bit.
- R5: While locked, `fas_err` pulses for one cycle after bit 8 of timeslot 0 of each alignment frame whose bits 2 to 8 differ from 0011011. It never pulses while searching.
- R6: A third errored alignment word in a row pulses `resync_met`. If `sync_hold` is 0, `los` rises in that same cycle and the search restarts. A correct word clears the run.
- R7: With `ext_crit_en`=1, a third 0 in a row in bit 2 of timeslot 0 of the frames between alignment words acts as in R6. With `ext_crit_en`=0 those bits have no effect.
- R8: With `sync_hold`=1, a met criterion still pulses `resync_met`, but `los` stays 0 and the run count starts again from zero.
- R9: A 0-to-1 transition of `resync_req` raises `los` in the next cycle and restarts the search. Holding the request high causes no further restart. A manual restart suppresses both strobes in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Received NRZ bit |
| sync_hold | input | 1 | 1 blocks automatic restart of the search |
| ext_crit_en | input | 1 | Enables the bit-2 error criterion |
| resync_req | input | 1 | Rising edge restarts the search |
| ts_cnt | output | 5 | Timeslot of the current bit |
| bit_cnt | output | 3 | Bit within the timeslot, 0 = bit 1 |
| align_frame | output | 1 | Current frame carries the alignment word |
| frame_sync | output | 1 | First bit of a frame |
| los | output | 1 | Loss of sync, high while searching |
| fas_err | output | 1 | Errored alignment word strobe |
| resync_met | output | 1 | Restart criterion met strobe |

## Verification
The hardest path to reach from the ports is a candidate that passes its middle-frame check and then fails at the second alignment word. Clean line data never produces it, because a real alignment word always confirms. The stimulus therefore corrupts the alignment word of every fourth frame while the block searches. Each candidate then passes the bit-2 check and is rejected one frame later, and `los` has to stay high throughout. The runs of three errors are reached by corrupting a counted number of timeslot 0 octets while locked, with and without the hold.

// File: rtl/e1fa_pkg.sv
package e1fa_pkg;
  localparam int FAS_LEN = 7;
  // bits 2..8 of timeslot 0, bit 2 in the MSB
  localparam logic [FAS_LEN-1:0] FAS_WORD = 7'b0011011;

  typedef enum logic [1:0] {
    ST_HUNT,
    ST_CONF_NFAS,
    ST_CONF_FAS,
    ST_LOCKED
  } e1fa_state_e;

  function automatic logic fas_hit(input logic [FAS_LEN-1:0] w);
    return w == FAS_WORD;
  endfunction
endpackage

// File: rtl/e1fa_window.sv
module e1fa_window #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         din,
  output logic [W-1:0] win
);
  logic [W-2:0] hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= {hist_q[W-3:0], din};
  end

  // oldest bit in the MSB, current bit in the LSB
  assign win = {hist_q, din};
endmodule

// File: rtl/e1fa_timebase.sv
module e1fa_timebase #(
  parameter int BPT = 8,
  parameter int TPF = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  output logic [$clog2(TPF)-1:0] ts,
  output logic [$clog2(BPT)-1:0] bt,
  output logic                   align,
  output logic                   word_end,
  output logic                   frame_start
);
  localparam int TW = $clog2(TPF);
  localparam int BW = $clog2(BPT);

  logic bit_last, ts_last;
  assign bit_last    = bt == BW'(BPT - 1);
  assign ts_last     = ts == TW'(TPF - 1);
  assign word_end    = (ts == '0) && bit_last;
  assign frame_start = (ts == '0) && (bt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts    <= '0;
      bt    <= '0;
      align <= 1'b0;
    end else if (load) begin
      ts    <= TW'(1);
      bt    <= '0;
      align <= 1'b1;
    end else begin
      bt <= bit_last ? '0 : bt + 1'b1;
      if (bit_last) ts <= ts_last ? '0 : ts + 1'b1;
      if (bit_last && ts_last) align <= ~align;
    end
  end
endmodule

// File: rtl/e1fa_err_run.sv
module e1fa_err_run #(
  parameter int LIMIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic chk,
  input  logic bad,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] run_q;

  assign hit = chk && bad && (run_q == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   run_q <= '0;
    else if (clr) run_q <= '0;
    else if (chk) run_q <= (bad && !hit) ? run_q + 1'b1 : '0;
  end
endmodule

// File: rtl/e1fa_ctrl.sv
module e1fa_ctrl
  import e1fa_pkg::*;
#(
  parameter int ERR_LIMIT = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FAS_LEN-1:0] win,
  input  logic               word_end,
  input  logic               align,
  input  logic               sync_hold,
  input  logic               ext_en,
  input  logic               resync_req,
  output logic               load,
  output logic               los,
  output logic               fas_err,
  output logic               resync_met,
  output logic               manual_edge
);
  e1fa_state_e state_q, state_d;
  logic req_q, locked, word_ok;
  logic fas_chk, fas_bad, b2_chk, b2_bad, fas_limit, b2_limit, crit;

  assign word_ok     = fas_hit(win);
  assign manual_edge = resync_req & ~req_q;
  assign locked      = state_q == ST_LOCKED;
  assign los         = ~locked;
  assign load        = (state_q == ST_HUNT) && !manual_edge && word_ok;

  assign fas_chk = locked && word_end && align;
  assign fas_bad = fas_chk && !word_ok;
  assign b2_chk  = locked && word_end && !align && ext_en;
  assign b2_bad  = b2_chk && !win[FAS_LEN-1];
  assign crit    = fas_limit | b2_limit;

  e1fa_err_run #(.LIMIT(ERR_LIMIT)) u_fas_run (
    .clk(clk), .rst_n(rst_n), .clr(!locked),
    .chk(fas_chk), .bad(fas_bad), .hit(fas_limit)
  );

  e1fa_err_run #(.LIMIT(ERR_LIMIT)) u_b2_run (
    .clk(clk), .rst_n(rst_n), .clr(!locked || !ext_en),
    .chk(b2_chk), .bad(b2_bad), .hit(b2_limit)
  );

  always_comb begin
    state_d = state_q;
    if (manual_edge) state_d = ST_HUNT;
    else begin
      case (state_q)
        ST_HUNT:      if (word_ok) state_d = ST_CONF_NFAS;
        ST_CONF_NFAS: if (word_end) state_d = win[FAS_LEN-1] ? ST_CONF_FAS : ST_HUNT;
        ST_CONF_FAS:  if (word_end) state_d = word_ok ? ST_LOCKED : ST_HUNT;
        ST_LOCKED:    if (crit && !sync_hold) state_d = ST_HUNT;
        default:      state_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_HUNT;
      req_q      <= 1'b0;
      fas_err    <= 1'b0;
      resync_met <= 1'b0;
    end else begin
      state_q    <= state_d;
      req_q      <= resync_req;
      fas_err    <= fas_bad && !manual_edge;
      resync_met <= crit && !manual_edge;
    end
  end
endmodule

// File: rtl/e1_frame_sync.sv
module e1_frame_sync
  import e1fa_pkg::*;
#(
  parameter int BITS_PER_TS  = 8,
  parameter int TS_PER_FRAME = 32,
  parameter int ERR_LIMIT    = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            rx_bit,
  input  logic                            sync_hold,
  input  logic                            ext_crit_en,
  input  logic                            resync_req,
  output logic [$clog2(TS_PER_FRAME)-1:0] ts_cnt,
  output logic [$clog2(BITS_PER_TS)-1:0]  bit_cnt,
  output logic                            align_frame,
  output logic                            frame_sync,
  output logic                            los,
  output logic                            fas_err,
  output logic                            resync_met
);
  logic [FAS_LEN-1:0] win;
  logic search_load, word_end, manual_edge;

  e1fa_window #(.W(FAS_LEN)) u_window (
    .clk(clk), .rst_n(rst_n), .din(rx_bit), .win(win)
  );

  e1fa_timebase #(.BPT(BITS_PER_TS), .TPF(TS_PER_FRAME)) u_timebase (
    .clk(clk), .rst_n(rst_n), .load(search_load),
    .ts(ts_cnt), .bt(bit_cnt), .align(align_frame),
    .word_end(word_end), .frame_start(frame_sync)
  );

  e1fa_ctrl #(.ERR_LIMIT(ERR_LIMIT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .win(win), .word_end(word_end),
    .align(align_frame), .sync_hold(sync_hold), .ext_en(ext_crit_en),
    .resync_req(resync_req), .load(search_load), .los(los),
    .fas_err(fas_err), .resync_met(resync_met), .manual_edge(manual_edge)
  );
endmodule

// File: rtl/e1fa_checks.sv
module e1fa_checks #(
  parameter int BPT = 8,
  parameter int TPF = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [$clog2(TPF)-1:0] ts_cnt,
  input logic [$clog2(BPT)-1:0] bit_cnt,
  input logic                   align_frame,
  input logic                   los,
  input logic                   fas_err,
  input logic                   resync_met,
  input logic                   sync_hold,
  input logic                   resync_req,
  input logic                   search_load
);
  localparam int TW = $clog2(TPF);
  localparam int BW = $clog2(BPT);

  assert_bit_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt == BW'(BPT - 1) |=> bit_cnt == '0);

  assert_ts_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt != BW'(BPT - 1)) && !search_load |=> $stable(ts_cnt));

  assert_lock_timing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(los) |-> (ts_cnt == TW'(1)) && (bit_cnt == '0) && align_frame);

  assert_no_err_in_search_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fas_err |-> $past(!los));

  assert_auto_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    resync_met && $past(!sync_hold) |-> los);

  assert_hold_keeps_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resync_met && $past(sync_hold) |-> !los);

  assert_manual_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resync_req) |=> los);
endmodule

bind e1_frame_sync e1fa_checks #(.BPT(BITS_PER_TS), .TPF(TS_PER_FRAME)) u_checks (
  .clk(clk), .rst_n(rst_n), .ts_cnt(ts_cnt), .bit_cnt(bit_cnt),
  .align_frame(align_frame), .los(los), .fas_err(fas_err),
  .resync_met(resync_met), .sync_hold(sync_hold), .resync_req(resync_req),
  .search_load(search_load)
);

// File: tb/test_e1_frame_sync.sv
module test_e1_frame_sync;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_bit = 1'b1, sync_hold = 1'b0, ext_crit_en = 1'b0, resync_req = 1'b0;
  logic [4:0] ts_cnt;
  logic [2:0] bit_cnt;
  logic align_frame, frame_sync, los, fas_err, resync_met;

  always #5 clk = ~clk;

  e1_frame_sync i_e1_frame_sync (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .sync_hold(sync_hold),
    .ext_crit_en(ext_crit_en), .resync_req(resync_req), .ts_cnt(ts_cnt),
    .bit_cnt(bit_cnt), .align_frame(align_frame), .frame_sync(frame_sync),
    .los(los), .fas_err(fas_err), .resync_met(resync_met)
  );

  int n_chk = 0, n_fail = 0;
  bit run_chk = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: behavioural state kept in integers and a queue
  bit hq[$];
  int m_st = 0, m_pos = 0, m_fc = 0, m_bc = 0;
  bit m_al = 0, m_prev = 0, m_fe = 0, m_rm = 0;

  always @(posedge clk) begin
    int word, np;
    bit na, fe, rm, lst, edg;
    if (!rst_n) begin
      hq.delete(); m_st = 0; m_pos = 0; m_al = 0; m_fc = 0; m_bc = 0;
      m_prev = 0; m_fe = 0; m_rm = 0;
    end else begin
      hq.push_back(rx_bit);
      if (hq.size() > 7) void'(hq.pop_front());
      word = 0;
      foreach (hq[i]) word = word * 2 + int'(hq[i]);
      edg = resync_req && !m_prev;
      m_prev = resync_req;
      lst = (m_pos == 7);
      fe = 0; rm = 0;
      np = (m_pos + 1) % 256;
      na = (m_pos == 255) ? !m_al : m_al;
      if (edg) m_st = 0;
      else if (m_st == 0) begin
        if (word == 27) begin np = 8; na = 1; m_st = 1; end
      end else if (m_st == 1) begin
        if (lst) m_st = (word >= 64) ? 2 : 0;
      end else if (m_st == 2) begin
        if (lst) begin
          if (word == 27) begin m_st = 3; m_fc = 0; m_bc = 0; end
          else m_st = 0;
        end
      end else begin
        if (!ext_crit_en) m_bc = 0;
        if (lst && m_al) begin
          if (word != 27) begin
            fe = 1; m_fc++;
            if (m_fc == 3) begin m_fc = 0; rm = 1; if (!sync_hold) m_st = 0; end
          end else m_fc = 0;
        end else if (lst && ext_crit_en) begin
          if (word < 64) begin
            m_bc++;
            if (m_bc == 3) begin m_bc = 0; rm = 1; if (!sync_hold) m_st = 0; end
          end else m_bc = 0;
        end
      end
      m_pos = np; m_al = na; m_fe = fe; m_rm = rm;
    end
  end

  // compare on every clock, away from the active edge
  int fe_n = 0, rm_n = 0, rise_n = 0;
  bit los_prev = 1;
  always @(negedge clk) begin
    if (rst_n && run_chk) begin
      chk(ts_cnt == 5'(m_pos / 8), "R2 R3 ts_cnt", ts_cnt, m_pos / 8);
      chk(bit_cnt == 3'(m_pos % 8), "R2 R3 bit_cnt", bit_cnt, m_pos % 8);
      chk(align_frame == m_al, "R2 R3 align_frame", align_frame, m_al);
      chk(frame_sync == (m_pos == 0), "R2 frame_sync", frame_sync, m_pos == 0);
      chk(los == (m_st != 3), "R4 los", los, m_st != 3);
      chk(fas_err == m_fe, "R5 fas_err", fas_err, m_fe);
      chk(resync_met == m_rm, "R6 resync_met", resync_met, m_rm);
      if (fas_err) fe_n++;
      if (resync_met) rm_n++;
      if (los && !los_prev) rise_n++;
      los_prev = los;
    end
  end

  // stream generator
  int g_pos = 0, g_frame = 0, corrupt_fas = 0, corrupt_b2 = 0;
  bit mod4 = 0, rnd = 0, g_al = 0, g_bad = 0;
  localparam logic [6:0] FAS_REF = 7'b0011011;

  task automatic send_bit(input bit b);
    @(posedge clk); #3; rx_bit = b;
  endtask

  task automatic run_bits(input int n);
    for (int k = 0; k < n; k++) begin
      bit b;
      if (g_pos == 0) begin
        g_al = (g_frame % 2 == 0);
        g_bad = 0;
        if (g_al && (corrupt_fas > 0 || (mod4 && g_frame % 4 == 2))) begin
          g_bad = 1;
          if (corrupt_fas > 0) corrupt_fas--;
        end
        if (!g_al && corrupt_b2 > 0) begin g_bad = 1; corrupt_b2--; end
      end
      if (g_pos < 8) begin
        if (g_pos == 0) b = 1;
        else if (g_al) b = FAS_REF[7 - g_pos] ^ (g_bad && g_pos == 4);
        else if (g_pos == 1) b = !g_bad;
        else b = (g_pos != 2);
      end else b = rnd ? 1'($urandom % 2) : 1'b1;
      send_bit(b);
      g_pos++;
      if (g_pos == 256) begin g_pos = 0; g_frame++; end
    end
  endtask

  task automatic slip(input int n);
    for (int k = 0; k < n; k++) send_bit(1'b1);
  endtask

  task automatic clear_counts();
    fe_n = 0; rm_n = 0; rise_n = 0;
  endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(los == 1'b1, "R1 los in reset", los, 1);
    chk(ts_cnt == 0 && bit_cnt == 0, "R1 counters in reset", {ts_cnt, bit_cnt}, 0);
    chk(!fas_err && !resync_met && !align_frame, "R1 strobes in reset",
        {fas_err, resync_met, align_frame}, 0);
    @(posedge clk); #3; rst_n = 1'b1; run_chk = 1;

    // initial acquisition at an arbitrary offset
    slip(37);
    run_bits(6 * 256);
    chk(los == 0, "R4 locked after acquisition", los, 0);

    // two errored words only
    clear_counts(); corrupt_fas = 2;
    run_bits(6 * 256);
    chk(fe_n == 2, "R5 two error strobes", fe_n, 2);
    chk(rm_n == 0 && los == 0, "R6 two errors keep lock", rm_n, 0);

    // three in a row, automatic restart
    clear_counts(); corrupt_fas = 3;
    run_bits(6 * 256);
    chk(rm_n == 1, "R6 criterion met once", rm_n, 1);
    chk(rise_n == 1, "R6 loss raised", rise_n, 1);
    run_bits(8 * 256);
    chk(los == 0, "R4 relocked after restart", los, 0);

    // three in a row with hold
    clear_counts(); sync_hold = 1; corrupt_fas = 3;
    run_bits(8 * 256);
    chk(rm_n == 1, "R8 criterion reported under hold", rm_n, 1);
    chk(rise_n == 0 && los == 0, "R8 lock kept under hold", rise_n, 0);
    sync_hold = 0;

    // bit-2 errors, criterion off then on
    clear_counts(); ext_crit_en = 0; corrupt_b2 = 3;
    run_bits(8 * 256);
    chk(rm_n == 0 && rise_n == 0, "R7 bit-2 errors ignored when off", rm_n, 0);
    clear_counts(); ext_crit_en = 1; corrupt_b2 = 3;
    run_bits(8 * 256);
    chk(rm_n == 1 && rise_n == 1, "R7 bit-2 criterion restarts", rm_n, 1);
    run_bits(8 * 256);
    chk(los == 0, "R7 relocked", los, 0);
    ext_crit_en = 0;

    // manual restart held high
    clear_counts(); resync_req = 1;
    run_bits(300);
    chk(rise_n == 1, "R9 single restart while held", rise_n, 1);
    resync_req = 0;
    run_bits(8 * 256);
    chk(los == 0, "R9 relocked after manual", los, 0);

    // candidates pass N+1 and fail N+2 forever
    clear_counts(); resync_req = 1; run_bits(1); resync_req = 0; mod4 = 1;
    run_bits(12 * 256);
    chk(los == 1, "R4 failed third frame keeps searching", los, 1);
    chk(fe_n == 0, "R5 no error strobe while searching", fe_n, 0);
    mod4 = 0;
    run_bits(8 * 256);
    chk(los == 0, "R4 locked once words are clean", los, 0);

    // bit slip while locked
    clear_counts();
    slip(3);
    run_bits(14 * 256);
    chk(rm_n == 1, "R6 slip detected", rm_n, 1);
    chk(los == 0, "R6 relocked after slip", los, 0);

    // random payload, model comparison only
    rnd = 1; slip(101);
    run_bits(20 * 256);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule